// File: doc/BRIEF.md
# Dynamic VID Transition Supervisor

This block supervises changes of the voltage-identification code while a core-voltage regulator is running. The incoming code is asynchronous. It passes through a synchronizer and is accepted only once it has held the same value on two consecutive synchronized samples. The block keeps an internal target code that the reference path follows. When the accepted code differs from the target, the target walks toward it by one code per programmable step interval. The target therefore never jumps, even when the code changes again part-way through a move.

While the target and the accepted code differ, the transition flag is high and the protection settings change. The overcurrent limit is raised by a programmable percentage above the nominal value. The overvoltage limit switches from the level that tracks the present code to the maximum-code level. The low-power request is masked for the whole move. It is honoured again only after a programmable settle delay that starts when the move completes. Thresholds and codes are plain digital words on ports.

Top module: `vid_slew_supervisor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `target_code` equals the parameter `RST_CODE`, `slew_active` is 0, `oc_limit` equals `oc_nom`, and `ov_limit` equals `ov_track`.
- R2: A value on `vid_in` is accepted only when two consecutive synchronized samples agree. With `SYNC_STAGES` = 2, a code held steady becomes the accepted code on the fourth rising edge after it appears. A value that lasts a single clock cycle is ignored: it leaves `target_code` and `slew_active` unchanged.
- R3: While a move is in progress, `target_code` changes by exactly +1 or -1 toward the accepted code. It steps once every `STEP_CYC` cycles, and the first step comes `STEP_CYC` cycles after the accepted code changes.
- R4: `slew_active` is 1 exactly when `target_code` differs from the accepted code. It clears in the same cycle that `target_code` reaches the accepted code, and `target_code` never changes while the block is idle.
- R5: While `slew_active` is 1, `oc_limit` equals floor(`oc_nom` × (100 + `OC_BOOST_PCT`) / 100); with the default of 140 this is 2.4 × `oc_nom`. While `slew_active` is 0, `oc_limit` equals `oc_nom` zero-extended.
- R6: While `slew_active` is 1, `ov_limit` equals `ov_max`. While it is 0, `ov_limit` equals `ov_track`.
- R7: While `slew_active` is 1, `lowpwr_en` is 0 whatever the value of `lowpwr_req`.
- R8: After a move completes, `lowpwr_en` stays 0 for exactly `SETTLE_CYC` cycles. It then follows `lowpwr_req`.
- R9: A new accepted code that arrives during a move redirects the stepping. The walk continues from the present `target_code`, with no jump and without restarting the step interval.
- R10: When the block is idle and settled, `lowpwr_en` equals `lowpwr_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_in | input | VID_W | Asynchronous requested voltage code |
| lowpwr_req | input | 1 | Low-power-state request, active high |
| oc_nom | input | OC_W | Nominal overcurrent threshold |
| ov_track | input | OV_W | Overvoltage level for the present code |
| ov_max | input | OV_W | Overvoltage level for the maximum code |
| target_code | output | VID_W | Stepped target code |
| slew_active | output | 1 | Transition in progress |
| oc_limit | output | OC_W+2 | Active overcurrent threshold |
| ov_limit | output | OV_W | Active overvoltage threshold |
| lowpwr_en | output | 1 | Low-power operation permitted |

## Verification
The hardest case to reach from the ports is a redirection. The new code has to be accepted while the step timer is part-way through an interval, and it has to point back across the present target. The stimulus times the second code change a fixed number of cycles after the first move starts. It also reverses direction, so the walk must turn around without losing its phase. A one-cycle glitch on the code checks the acceptance filter. The settle delay is measured from the exact cycle the move completes, with the low-power request held throughout.

// File: rtl/vid_slew_pkg.sv
package vid_slew_pkg;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_UP   = 2'b01,
      STEP_DOWN = 2'b10
   } step_dir_e;

endpackage

// File: rtl/vid_code_qualifier.sv
module vid_code_qualifier #(
   parameter int VID_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RST_CODE    = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VID_W-1:0] vid_async,
   output logic [VID_W-1:0] vid_accepted
);
   localparam logic [VID_W-1:0] RST_V = VID_W'(RST_CODE);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("vid_code_qualifier: SYNC_STAGES must be at least 2");
   end

   logic [VID_W-1:0] sync_q [SYNC_STAGES];
   logic [VID_W-1:0] prev_q;
   logic [VID_W-1:0] acc_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[0] <= RST_V;
            else        sync_q[0] <= vid_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[i] <= RST_V;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= RST_V;
         acc_q  <= RST_V;
      end else begin
         prev_q <= sync_q[SYNC_STAGES-1];
         if (sync_q[SYNC_STAGES-1] == prev_q) acc_q <= prev_q;
      end
   end

   assign vid_accepted = acc_q;

endmodule

// File: rtl/vid_step_engine.sv
module vid_step_engine
   import vid_slew_pkg::*;
#(
   parameter int VID_W    = 8,
   parameter int STEP_CYC = 16,
   parameter int RST_CODE = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VID_W-1:0] goal,
   output logic [VID_W-1:0] target,
   output logic             moving
);
   localparam int TMR_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
   localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STEP_CYC - 1);

   if (STEP_CYC < 1) begin : g_bad_step
      $error("vid_step_engine: STEP_CYC must be at least 1");
   end

   logic [VID_W-1:0] tgt_q;
   logic [TMR_W-1:0] tmr_q;
   step_dir_e        dir;

   always_comb begin
      if (goal > tgt_q)      dir = STEP_UP;
      else if (goal < tgt_q) dir = STEP_DOWN;
      else                   dir = STEP_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q <= VID_W'(RST_CODE);
         tmr_q <= '0;
      end else if (dir == STEP_HOLD) begin
         tmr_q <= '0;
      end else if (tmr_q == TMR_LAST) begin
         tmr_q <= '0;
         if (dir == STEP_UP) tgt_q <= tgt_q + 1'b1;
         else                tgt_q <= tgt_q - 1'b1;
      end else begin
         tmr_q <= tmr_q + 1'b1;
      end
   end

   assign target = tgt_q;
   assign moving = (dir != STEP_HOLD);

endmodule

// File: rtl/vid_guard_select.sv
module vid_guard_select #(
   parameter int OC_W         = 12,
   parameter int OV_W         = 12,
   parameter int OC_BOOST_PCT = 140,
   parameter int SETTLE_CYC   = 2500
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            moving,
   input  logic            lowpwr_req,
   input  logic [OC_W-1:0] oc_nom,
   input  logic [OV_W-1:0] ov_track,
   input  logic [OV_W-1:0] ov_max,
   output logic [OC_W+1:0] oc_limit,
   output logic [OV_W-1:0] ov_limit,
   output logic            lowpwr_en
);
   localparam int OC_OUT_W = OC_W + 2;
   localparam int PROD_W   = OC_W + 10;
   localparam int HOLD_W   = $clog2(SETTLE_CYC + 1);

   if (OC_BOOST_PCT < 0 || OC_BOOST_PCT > 300) begin : g_bad_pct
      $error("vid_guard_select: OC_BOOST_PCT must lie in 0..300");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("vid_guard_select: SETTLE_CYC must be at least 1");
   end

   logic [OC_OUT_W-1:0] oc_boosted;

   if (OC_BOOST_PCT == 0) begin : g_no_boost
      assign oc_boosted = OC_OUT_W'(oc_nom);
   end else begin : g_boost
      logic [PROD_W-1:0] prod;
      assign prod       = PROD_W'(oc_nom) * PROD_W'(100 + OC_BOOST_PCT);
      assign oc_boosted = OC_OUT_W'(prod / PROD_W'(100));
   end

   logic [HOLD_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            hold_q <= '0;
      else if (moving)       hold_q <= HOLD_W'(SETTLE_CYC);
      else if (hold_q != '0) hold_q <= hold_q - 1'b1;
   end

   assign oc_limit  = moving ? oc_boosted : OC_OUT_W'(oc_nom);
   assign ov_limit  = moving ? ov_max : ov_track;
   assign lowpwr_en = lowpwr_req && !moving && (hold_q == '0);

endmodule

// File: rtl/vid_slew_supervisor.sv
module vid_slew_supervisor #(
   parameter int VID_W        = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int STEP_CYC     = 16,
   parameter int SETTLE_CYC   = 2500,
   parameter int RST_CODE     = 64,
   parameter int OC_W         = 12,
   parameter int OV_W         = 12,
   parameter int OC_BOOST_PCT = 140
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VID_W-1:0] vid_in,
   input  logic             lowpwr_req,
   input  logic [OC_W-1:0]  oc_nom,
   input  logic [OV_W-1:0]  ov_track,
   input  logic [OV_W-1:0]  ov_max,
   output logic [VID_W-1:0] target_code,
   output logic             slew_active,
   output logic [OC_W+1:0]  oc_limit,
   output logic [OV_W-1:0]  ov_limit,
   output logic             lowpwr_en
);
   if (RST_CODE < 0 || RST_CODE >= (1 << VID_W)) begin : g_bad_rst
      $error("vid_slew_supervisor: RST_CODE out of range");
   end

   logic [VID_W-1:0] vid_acc;

   vid_code_qualifier #(
      .VID_W(VID_W), .SYNC_STAGES(SYNC_STAGES), .RST_CODE(RST_CODE)
   ) u_qual (
      .clk(clk), .rst_n(rst_n), .vid_async(vid_in), .vid_accepted(vid_acc)
   );

   vid_step_engine #(
      .VID_W(VID_W), .STEP_CYC(STEP_CYC), .RST_CODE(RST_CODE)
   ) u_step (
      .clk(clk), .rst_n(rst_n), .goal(vid_acc),
      .target(target_code), .moving(slew_active)
   );

   vid_guard_select #(
      .OC_W(OC_W), .OV_W(OV_W), .OC_BOOST_PCT(OC_BOOST_PCT), .SETTLE_CYC(SETTLE_CYC)
   ) u_guard (
      .clk(clk), .rst_n(rst_n), .moving(slew_active), .lowpwr_req(lowpwr_req),
      .oc_nom(oc_nom), .ov_track(ov_track), .ov_max(ov_max),
      .oc_limit(oc_limit), .ov_limit(ov_limit), .lowpwr_en(lowpwr_en)
   );

endmodule

// File: rtl/vid_slew_checker.sv
module vid_slew_checker #(
   parameter int VID_W = 8,
   parameter int OC_W  = 12,
   parameter int OV_W  = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [VID_W-1:0] target_code,
   input logic             slew_active,
   input logic             lowpwr_en,
   input logic [OC_W-1:0]  oc_nom,
   input logic [OC_W+1:0]  oc_limit,
   input logic [OV_W-1:0]  ov_track,
   input logic [OV_W-1:0]  ov_max,
   input logic [OV_W-1:0]  ov_limit
);
   AST_TGT_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(target_code) |->
         (({1'b0, target_code} == {1'b0, $past(target_code)} + 1'b1) ||
          ({1'b0, target_code} + 1'b1 == {1'b0, $past(target_code)}))); // R3

   AST_TGT_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(target_code) |-> $past(slew_active)); // R4

   AST_OC_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      slew_active |-> (oc_limit >= {2'b00, oc_nom})); // R5

   AST_OV_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      slew_active |-> (ov_limit == ov_max)); // R6

   AST_OV_TRACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !slew_active |-> (ov_limit == ov_track)); // R6

   AST_LP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      slew_active |-> !lowpwr_en); // R7

   AST_LP_SETTLE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slew_active) |-> !lowpwr_en); // R8
endmodule

bind vid_slew_supervisor vid_slew_checker #(
   .VID_W(VID_W), .OC_W(OC_W), .OV_W(OV_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .target_code(target_code), .slew_active(slew_active),
   .lowpwr_en(lowpwr_en), .oc_nom(oc_nom), .oc_limit(oc_limit),
   .ov_track(ov_track), .ov_max(ov_max), .ov_limit(ov_limit)
);

// File: tb/test_vid_slew_supervisor.sv
`timescale 1ns/1ps
module test_vid_slew_supervisor;
   localparam int VW = 8, STEP = 6, SETTLE = 30, RSTC = 64, OCW = 12, OVW = 12, PCT = 140;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [VW-1:0] vid_in = VW'(RSTC);
   logic lowpwr_req = 1'b1;
   logic [OCW-1:0] oc_nom = 12'd1000;
   logic [OVW-1:0] ov_track = 12'd300;
   logic [OVW-1:0] ov_max = 12'd500;
   logic [VW-1:0] target_code;
   logic slew_active, lowpwr_en;
   logic [OCW+1:0] oc_limit;
   logic [OVW-1:0] ov_limit;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vid_slew_supervisor #(
      .VID_W(VW), .SYNC_STAGES(2), .STEP_CYC(STEP), .SETTLE_CYC(SETTLE),
      .RST_CODE(RSTC), .OC_W(OCW), .OV_W(OVW), .OC_BOOST_PCT(PCT)
   ) i_vid_slew_supervisor (
      .clk(clk), .rst_n(rst_n), .vid_in(vid_in), .lowpwr_req(lowpwr_req),
      .oc_nom(oc_nom), .ov_track(ov_track), .ov_max(ov_max),
      .target_code(target_code), .slew_active(slew_active),
      .oc_limit(oc_limit), .ov_limit(ov_limit), .lowpwr_en(lowpwr_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: sample history, accepted code, target, step phase, settle count.
   int hist[$];
   int m_acc = RSTC, m_tgt = RSTC, m_phase = 0, m_settle = 0;

   always @(posedge clk) begin
      int a, t, p, s;
      bit act;
      act = (m_acc != m_tgt);
      a = m_acc; t = m_tgt; p = m_phase; s = m_settle;
      if (!rst_n) begin
         hist = {RSTC, RSTC, RSTC};
         a = RSTC; t = RSTC; p = 0; s = 0;
      end else begin
         // hist[0] newest sync output .. hist[2] previous sync output
         if (hist[1] == hist[2]) a = hist[1];
         if (!act) p = 0;
         else if (p == STEP - 1) begin
            p = 0;
            t = (m_acc > m_tgt) ? m_tgt + 1 : m_tgt - 1;
         end else p = p + 1;
         if (act) s = SETTLE;
         else if (s > 0) s = s - 1;
         hist.push_front(int'(vid_in));
         void'(hist.pop_back());
      end
      m_acc = a; m_tgt = t; m_phase = p; m_settle = s;
   end

   always @(negedge clk) begin
      bit act;
      int oc_exp;
      if (rst_n && !done) begin
         act = (m_acc != m_tgt);
         oc_exp = act ? (int'(oc_nom) * (100 + PCT)) / 100 : int'(oc_nom);
         chk(target_code == VW'(m_tgt), "R3/R9 target", int'(target_code), m_tgt);
         chk(slew_active == act, "R4 active", int'(slew_active), int'(act));
         chk(int'(oc_limit) == oc_exp, "R5 oc_limit", int'(oc_limit), oc_exp);
         chk(ov_limit == (act ? ov_max : ov_track), "R6 ov_limit", int'(ov_limit),
             act ? int'(ov_max) : int'(ov_track));
         chk(lowpwr_en == (lowpwr_req && !act && m_settle == 0), "R7/R8/R10 lowpwr_en",
             int'(lowpwr_en), int'(lowpwr_req && !act && m_settle == 0));
      end
   end

   task automatic drive_vid(input int v);
      @(negedge clk); #1 vid_in = VW'(v);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (slew_active);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      done = 1'b1;
      summary();
   end

   initial begin
      int n;
      repeat (4) @(negedge clk);
      chk(target_code == VW'(RSTC), "R1 target in reset", int'(target_code), RSTC);
      chk(!slew_active, "R1 active in reset", int'(slew_active), 0);
      chk(oc_limit == 14'd1000, "R1 oc in reset", int'(oc_limit), 1000);
      chk(ov_limit == 12'd300, "R1 ov in reset", int'(ov_limit), 300);
      #1 rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(lowpwr_en == 1'b1, "R10 idle lowpwr", int'(lowpwr_en), 1);

      // R2: one-cycle glitch is filtered out
      drive_vid(90);
      drive_vid(RSTC);
      repeat (12) @(negedge clk);
      chk(target_code == VW'(RSTC), "R2 glitch target", int'(target_code), RSTC);
      chk(!slew_active, "R2 glitch active", int'(slew_active), 0);

      // R2/R3: single step, accepted on 4th edge, first step STEP cycles later
      drive_vid(65);
      repeat (3) @(negedge clk);
      chk(!slew_active, "R2 not yet accepted", int'(slew_active), 0);
      @(negedge clk);
      chk(slew_active, "R2 accepted on 4th edge", int'(slew_active), 1);
      chk(oc_limit == 14'd2400, "R5 boosted oc", int'(oc_limit), 2400);
      chk(ov_limit == 12'd500, "R6 max ov", int'(ov_limit), 500);
      chk(!lowpwr_en, "R7 lowpwr masked", int'(lowpwr_en), 0);
      repeat (STEP - 1) @(negedge clk);
      chk(target_code == VW'(RSTC), "R3 before step", int'(target_code), RSTC);
      @(negedge clk);
      chk(target_code == 8'd65, "R3 single step", int'(target_code), 65);
      chk(!slew_active, "R4 clears on arrival", int'(slew_active), 0);
      n = 0;
      while (!lowpwr_en && n < 1000) begin @(negedge clk); n++; end
      chk(n == SETTLE, "R8 settle delay", n, SETTLE);

      // multi-step up, request dropped and raised mid-move
      drive_vid(72);
      repeat (20) @(negedge clk);
      #1 lowpwr_req = 1'b0;
      repeat (10) @(negedge clk);
      #1 lowpwr_req = 1'b1;
      wait_idle();
      chk(target_code == 8'd72, "R3 multi-step end", int'(target_code), 72);
      repeat (SETTLE + 2) @(negedge clk);

      // R9: redirect upward move back down across the target
      drive_vid(80);
      repeat (4 + 3 * STEP + 2) @(negedge clk);
      chk(target_code == 8'd75, "R9 mid-move target", int'(target_code), 75);
      drive_vid(70);
      wait_idle();
      chk(target_code == 8'd70, "R9 redirected end", int'(target_code), 70);
      repeat (SETTLE + 2) @(negedge clk);

      // downward move with different thresholds
      #1 oc_nom = 12'd1234; ov_track = 12'd250; ov_max = 12'd777;
      drive_vid(60);
      repeat (6) @(negedge clk);
      chk(oc_limit == 14'd2961, "R5 boosted oc 1234", int'(oc_limit), 2961);
      wait_idle();
      chk(target_code == 8'd60, "R3 down move end", int'(target_code), 60);
      repeat (SETTLE + 2) @(negedge clk);
      #1 lowpwr_req = 1'b0;
      @(negedge clk);
      chk(!lowpwr_en, "R10 follows request low", int'(lowpwr_en), 0);
      #1 lowpwr_req = 1'b1;
      @(negedge clk);
      chk(lowpwr_en, "R10 follows request high", int'(lowpwr_en), 1);

      // redirect onto the present target: move stops at once
      drive_vid(66);
      repeat (4 + 2 * STEP + 1) @(negedge clk);
      drive_vid(int'(target_code) + 0);
      repeat (STEP + 6) @(negedge clk);
      chk(!slew_active, "R9 redirect to present target", int'(slew_active), 0);
      repeat (SETTLE + 5) @(negedge clk);

      done = 1'b1;
      summary();
   end
endmodule